// File: doc/BRIEF.md
# Planar Video Memory Address Steering

This block sits between a host bus and a video memory that is split into four byte-wide planes. For every host access it works out which planes a write may touch, which plane a read returns, and which offset inside each plane is used. It supports two ways of using the memory: linear planar access, where every plane sees the same offset, and odd/even access, where even and odd host bytes go to different plane pairs.

The control bits live in three register groups. Two groups are reached through an index register and a data register. The third is a single output-control register. Writes, reads and offset forming each have their own enable bit, so software can turn odd/even behaviour on for each one on its own. A page bit chooses the lower or upper half of the plane space when the low address bit is taken out of the offset. The outputs are combinational from the registered controls and the current host address. The surrounding memory controller uses them in the same cycle as the host strobe.

Top module: `plane_addr_steer`

## Requirements
- R1: After a synchronous reset every control bit is 0. A host write then enables no plane, the read plane select is 0, and the plane offset equals the host offset.
- R2: When sequencer index 4 data bit 2 is 1, a host write enables exactly the planes set in the 4-bit map mask (sequencer index 2, data bits 3:0; bit n is plane n).
- R3: When sequencer index 4 data bit 2 is 0, a host write with address bit 0 at 0 enables the map mask ANDed with 4'b0101. With address bit 0 at 1 it enables the map mask ANDed with 4'b1010.
- R4: When graphics index 5 data bit 4 is 1, the read plane select is {read map bit 1, host address bit 0}. Otherwise it equals the read map select (graphics index 4, data bits 1:0).
- R5: When graphics index 6 data bit 1 is 1, plane offset bits 15:1 equal host address bits 15:1. Otherwise the plane offset equals the host address.
- R6: When offsets are chained (R5), plane offset bit 0 equals the page bit, which is bit 5 of the output-control register.
- R7: The write-enable mask is 0 whenever the host strobe is low or the access is a read.
- R8: A data write uses the index held in that group's index register. A data write to an index with no register behind it changes no control.
- R9: A control write takes effect on the cycle after the clock edge that captures it. In the cycle of the write itself, the outputs still reflect the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_idx_wr | input | 1 | Load sequencer index from cfg_wdata |
| seq_dat_wr | input | 1 | Write cfg_wdata to the indexed sequencer register |
| gfx_idx_wr | input | 1 | Load graphics index from cfg_wdata |
| gfx_dat_wr | input | 1 | Write cfg_wdata to the indexed graphics register |
| outctl_wr | input | 1 | Write the output-control register |
| cfg_wdata | input | 8 | Control write data |
| host_req | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Host offset |
| plane_wen | output | 4 | Per-plane write enables |
| rd_plane | output | 2 | Plane returned on reads |
| plane_addr | output | 16 | Offset inside each plane |

## Verification
The host outputs have no latency. They are due in the same cycle as the host strobe and address, so the bench drives host inputs on the falling edge and samples shortly after, before the next rising edge. Control writes need one rising edge to land. The bench therefore checks the old outputs in the cycle of a data write and the new outputs right after the capturing edge. Random control patterns and random host accesses are compared with a bench model that keeps its own copy of every control write.

// File: rtl/steer_pkg.sv
package steer_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 16;
    localparam int PLANES  = 4;
    localparam int PSEL_W  = $clog2(PLANES);

    // index values decoded inside the two indexed groups
    localparam logic [DATA_W-1:0] SEQ_IX_MASK  = 8'h02;
    localparam logic [DATA_W-1:0] SEQ_IX_MODE  = 8'h04;
    localparam logic [DATA_W-1:0] GFX_IX_RMAP  = 8'h04;
    localparam logic [DATA_W-1:0] GFX_IX_MODE  = 8'h05;
    localparam logic [DATA_W-1:0] GFX_IX_CHAIN = 8'h06;

    localparam int BIT_WR_LINEAR = 2;
    localparam int BIT_RD_OE     = 4;
    localparam int BIT_CHAIN     = 1;
    localparam int BIT_PAGE      = 5;

    typedef struct packed {
        logic [PLANES-1:0] map_mask;
        logic              wr_linear;
        logic              rd_oe;
        logic              chain_oe;
        logic [PSEL_W-1:0] rd_map;
        logic              hi_page;
    } steer_cfg_t;

    typedef struct packed {
        logic              req;
        logic              we;
        logic [ADDR_W-1:0] addr;
    } host_acc_t;

    function automatic logic [PSEL_W-1:0] pick_rd_plane(
        input logic [PSEL_W-1:0] rmap, input logic oe, input logic a0);
        return oe ? {rmap[PSEL_W-1:1], a0} : rmap;
    endfunction
endpackage

// File: rtl/steer_cfg.sv
module steer_cfg
    import steer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              seq_idx_wr,
    input  logic              seq_dat_wr,
    input  logic              gfx_idx_wr,
    input  logic              gfx_dat_wr,
    input  logic              outctl_wr,
    input  logic [DATA_W-1:0] wdata,
    output steer_cfg_t        cfg
);
    logic [DATA_W-1:0] seq_ix, gfx_ix;

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_ix <= '0;
            gfx_ix <= '0;
            cfg    <= '0;
        end else begin
            if (seq_idx_wr) seq_ix <= wdata;
            if (gfx_idx_wr) gfx_ix <= wdata;
            if (seq_dat_wr) begin
                case (seq_ix)
                    SEQ_IX_MASK: cfg.map_mask  <= wdata[PLANES-1:0];
                    SEQ_IX_MODE: cfg.wr_linear <= wdata[BIT_WR_LINEAR];
                    default: ;
                endcase
            end
            if (gfx_dat_wr) begin
                case (gfx_ix)
                    GFX_IX_RMAP:  cfg.rd_map   <= wdata[PSEL_W-1:0];
                    GFX_IX_MODE:  cfg.rd_oe    <= wdata[BIT_RD_OE];
                    GFX_IX_CHAIN: cfg.chain_oe <= wdata[BIT_CHAIN];
                    default: ;
                endcase
            end
            if (outctl_wr) cfg.hi_page <= wdata[BIT_PAGE];
        end
    end

    // R8: with no data write, the decoded controls hold
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(seq_dat_wr || gfx_dat_wr || outctl_wr) |=> $stable(cfg));
    // R8: an unmapped sequencer index leaves the mask and mode unchanged
    assert_unmapped_R8: assert property (@(posedge clk) disable iff (rst)
        (seq_dat_wr && seq_ix != SEQ_IX_MASK && seq_ix != SEQ_IX_MODE)
        |=> ($stable(cfg.map_mask) && $stable(cfg.wr_linear)));
endmodule

// File: rtl/steer_map.sv
module steer_map
    import steer_pkg::*;
(
    input  steer_cfg_t        cfg,
    input  host_acc_t         acc,
    output logic [PLANES-1:0] wen,
    output logic [PSEL_W-1:0] rsel,
    output logic [ADDR_W-1:0] offs
);
    logic wr_acc;
    assign wr_acc = acc.req & acc.we;

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        localparam logic ODD = ((p % 2) == 1);
        logic pair_ok;
        assign pair_ok = cfg.wr_linear | (acc.addr[0] == ODD);
        assign wen[p]  = wr_acc & cfg.map_mask[p] & pair_ok;
    end

    assign rsel = pick_rd_plane(cfg.rd_map, cfg.rd_oe, acc.addr[0]);
    assign offs = cfg.chain_oe ? {acc.addr[ADDR_W-1:1], cfg.hi_page} : acc.addr;
endmodule

// File: rtl/plane_addr_steer.sv
module plane_addr_steer
    import steer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              seq_idx_wr,
    input  logic              seq_dat_wr,
    input  logic              gfx_idx_wr,
    input  logic              gfx_dat_wr,
    input  logic              outctl_wr,
    input  logic [7:0]        cfg_wdata,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [15:0]       host_addr,
    output logic [3:0]        plane_wen,
    output logic [1:0]        rd_plane,
    output logic [15:0]       plane_addr
);
    steer_cfg_t cfg;
    host_acc_t  acc;

    assign acc = '{req: host_req, we: host_we, addr: host_addr};

    steer_cfg u_cfg (
        .clk(clk), .rst(rst),
        .seq_idx_wr(seq_idx_wr), .seq_dat_wr(seq_dat_wr),
        .gfx_idx_wr(gfx_idx_wr), .gfx_dat_wr(gfx_dat_wr),
        .outctl_wr(outctl_wr), .wdata(cfg_wdata), .cfg(cfg)
    );

    steer_map u_map (
        .cfg(cfg), .acc(acc),
        .wen(plane_wen), .rsel(rd_plane), .offs(plane_addr)
    );

    assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !(host_req && host_we) |-> plane_wen == '0);
    assert_pair_R3: assert property (@(posedge clk) disable iff (rst)
        (!cfg.wr_linear && !host_addr[0]) |-> (plane_wen & 4'b1010) == '0);
    assert_subset_R2: assert property (@(posedge clk) disable iff (rst)
        (plane_wen & ~cfg.map_mask) == '0);
    assert_rdsel_R4: assert property (@(posedge clk) disable iff (rst)
        cfg.rd_oe |-> rd_plane[0] == host_addr[0]);
    assert_chain_R5: assert property (@(posedge clk) disable iff (rst)
        cfg.chain_oe |-> plane_addr[15:1] == host_addr[15:1]);
    assert_pass_R5: assert property (@(posedge clk) disable iff (rst)
        !cfg.chain_oe |-> plane_addr == host_addr);
endmodule

// File: tb/plane_addr_steer_tb.sv
`timescale 1ns/1ps
module plane_addr_steer_tb;
    logic clk = 0, rst = 1;
    logic seq_idx_wr = 0, seq_dat_wr = 0, gfx_idx_wr = 0, gfx_dat_wr = 0, outctl_wr = 0;
    logic [7:0]  cfg_wdata = 0;
    logic        host_req = 0, host_we = 0;
    logic [15:0] host_addr = 0;
    logic [3:0]  plane_wen;
    logic [1:0]  rd_plane;
    logic [15:0] plane_addr;

    int total = 0, bad = 0;

    // bench model of the controls
    logic [3:0] m_mask = 0; logic m_lin = 0, m_roe = 0, m_chain = 0, m_page = 0;
    logic [1:0] m_rmap = 0;

    always #2.5 clk = ~clk;

    plane_addr_steer u_dut (.*);

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic logic [3:0] exp_wen(input logic r, input logic w, input logic [15:0] a);
        if (!(r && w)) return 4'b0;
        if (m_lin) return m_mask;
        return m_mask & (a[0] ? 4'b1010 : 4'b0101);
    endfunction
    function automatic logic [1:0] exp_rd(input logic [15:0] a);
        return m_roe ? {m_rmap[1], a[0]} : m_rmap;
    endfunction
    function automatic logic [15:0] exp_off(input logic [15:0] a);
        return m_chain ? {a[15:1], m_page} : a;
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        #1;
        chk({tag, " wen R2/R3/R7"}, {12'b0, plane_wen}, {12'b0, exp_wen(host_req, host_we, host_addr)});
        chk({tag, " rd R4"}, {14'b0, rd_plane}, {14'b0, exp_rd(host_addr)});
        chk({tag, " off R5/R6"}, plane_addr, exp_off(host_addr));
    endtask

    task automatic model_write(input int grp, input logic [7:0] ix, input logic [7:0] d);
        if (grp == 0) begin
            if (ix == 8'h02) m_mask = d[3:0];
            if (ix == 8'h04) m_lin = d[2];
        end else if (grp == 1) begin
            if (ix == 8'h04) m_rmap = d[1:0];
            if (ix == 8'h05) m_roe = d[4];
            if (ix == 8'h06) m_chain = d[1];
        end else m_page = d[5];
    endtask

    // grp 0 = sequencer, 1 = graphics, 2 = output control
    task automatic wr_cfg(input int grp, input logic [7:0] ix, input logic [7:0] d);
        @(negedge clk);
        if (grp != 2) begin
            cfg_wdata = ix;
            if (grp == 0) seq_idx_wr = 1; else gfx_idx_wr = 1;
            @(negedge clk);
            seq_idx_wr = 0; gfx_idx_wr = 0;
        end
        cfg_wdata = d;
        if (grp == 0) seq_dat_wr = 1; else if (grp == 1) gfx_dat_wr = 1; else outctl_wr = 1;
        @(negedge clk);
        seq_dat_wr = 0; gfx_dat_wr = 0; outctl_wr = 0;
        model_write(grp, ix, d);
    endtask

    task automatic host(input logic r, input logic w, input logic [15:0] a, input string tag);
        @(negedge clk);
        host_req = r; host_we = w; host_addr = a;
        check_all(tag);
    endtask

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        host(1, 1, 16'h0001, "R1 a");
        host(1, 0, 16'h1234, "R1 b");
        chk("R1 wen", {12'b0, plane_wen}, 16'h0);
        chk("R1 off", plane_addr, 16'h1234);
        // R2 linear writes
        wr_cfg(0, 8'h02, 8'h0F);
        wr_cfg(0, 8'h04, 8'h04);
        host(1, 1, 16'h0003, "R2");
        chk("R2 mask", {12'b0, plane_wen}, 16'h000F);
        // R3 odd/even writes
        wr_cfg(0, 8'h04, 8'h00);
        host(1, 1, 16'h0010, "R3 even");
        chk("R3 even", {12'b0, plane_wen}, 16'h0005);
        host(1, 1, 16'h0011, "R3 odd");
        chk("R3 odd", {12'b0, plane_wen}, 16'h000A);
        // R7 no write access
        host(0, 1, 16'h0011, "R7 idle");
        chk("R7 idle", {12'b0, plane_wen}, 16'h0);
        host(1, 0, 16'h0011, "R7 read");
        // R4 read select
        wr_cfg(1, 8'h04, 8'h03);
        host(1, 0, 16'h0010, "R4 off");
        chk("R4 off", {14'b0, rd_plane}, 16'h3);
        wr_cfg(1, 8'h05, 8'h10);
        host(1, 0, 16'h0010, "R4 even");
        chk("R4 even", {14'b0, rd_plane}, 16'h2);
        host(1, 0, 16'h0011, "R4 odd");
        chk("R4 odd", {14'b0, rd_plane}, 16'h3);
        // R5 / R6 chain and page
        wr_cfg(1, 8'h06, 8'h02);
        host(1, 0, 16'hABCD, "R5 lo");
        chk("R5 lo", plane_addr, 16'hABCC);
        wr_cfg(2, 8'h00, 8'h20);
        host(1, 0, 16'hABCC, "R6 hi");
        chk("R6 hi", plane_addr, 16'hABCD);
        // R8 unmapped indexes
        wr_cfg(0, 8'h01, 8'hFF);
        wr_cfg(1, 8'h07, 8'hFF);
        host(1, 1, 16'h0010, "R8 unmapped");
        chk("R8 unmapped", {12'b0, plane_wen}, 16'h0005);
        // R9 timing: sequencer index left at 1, set to 2 then data write
        @(negedge clk);
        cfg_wdata = 8'h02; seq_idx_wr = 1;
        @(negedge clk);
        seq_idx_wr = 0; cfg_wdata = 8'h01; seq_dat_wr = 1;
        host_req = 1; host_we = 1; host_addr = 16'h0000;
        #1 chk("R9 old", {12'b0, plane_wen}, 16'h0005);
        @(negedge clk);
        seq_dat_wr = 0; m_mask = 4'h1;
        #1 chk("R9 new", {12'b0, plane_wen}, 16'h0001);
        // random mix
        for (int i = 0; i < 400; i++) begin
            int g;
            logic [7:0] ix, d;
            g  = $urandom_range(0, 2);
            ix = (g == 0) ? (($urandom_range(0, 1) != 0) ? 8'h02 : 8'h04)
                          : 8'h04 + 8'($urandom_range(0, 2));
            d  = 8'($urandom);
            wr_cfg(g, ix, d);
            for (int k = 0; k < 3; k++)
                host(1'($urandom), 1'($urandom), 16'($urandom), "rand");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule